// File: doc/BRIEF.md
# PDM Microphone Decimator

This block drives the bit clock of a mono PDM MEMS microphone whose channel-select pin is strapped low. Because that pin is strapped, the microphone produces a single channel and the block captures its one-bit stream on one clock edge only. Each captured bit is turned into a signed ±1 value so that the stream carries no DC offset. The values then pass through a chain of sliding-window sum stages, and the result is decimated to PCM words at an audio rate close to 48 kHz.

The microphone clock is the system clock divided by an integer. The default divisor of 50 gives 2 MHz from a 100 MHz system clock. Every stage outputs the sum of the latest WIN values it has received and updates that sum on every new value. The stage is built as an accumulator that adds the newest value and subtracts the value that entered WIN inputs earlier. Each stage widens the word by ceil(log2(WIN)) bits, so the chain cannot overflow. The block emits one PCM word for every WIN bits, and that word is the top PCM_W bits of the final sum.

Top module: `pdm_mic_decimator`

## Requirements
- R1: `mic_clk` is periodic with a period of CLK_DIV system cycles. It is high for CLK_DIV/2 cycles of each period and low for the remaining cycles, except in the first period after reset.
- R2: One bit is captured in each microphone clock period. The captured value is the `pdm_data` level registered on the system edge one cycle before the last low cycle of the period ends, so a level held from the rising edge of `mic_clk` onward is the level taken.
- R3: A captured 0 enters the filter as +1 and a captured 1 enters it as −1. A run of zeros long enough to fill every window therefore gives the positive full-scale value WIN^STAGES, and a run of ones gives its negative.
- R4: Each stage outputs the exact sum of its WIN most recent inputs, where inputs older than the last reset count as zero. The stage updates only when a new input arrives.
- R5: STAGES such stages are cascaded. Stage k (k counted from 1) is 2+k·ceil(log2(WIN)) bits wide, and no stage wraps, even at full scale.
- R6: Exactly one PCM word is produced per WIN captured bits. The words follow the WIN-th, 2·WIN-th, … bit since reset.
- R7: `pcm_valid` is high for exactly one system cycle per word, and `pcm_data` carries that word while it is high.
- R8: `pcm_data` is the final sum arithmetically shifted right by (final width − PCM_W), with the low bits dropped. When the final width is smaller than PCM_W, the sum is shifted left instead.
- R9: Reset clears the clock divider, every accumulator and every delay line. While in reset, `mic_clk`, `pcm_valid` and `pcm_data` are all 0, and the first word after reset depends only on bits captured after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pdm_data | input | 1 | One-bit data from the microphone |
| mic_clk | output | 1 | Bit clock to the microphone |
| pcm_data | output | PCM_W | Signed PCM word |
| pcm_valid | output | 1 | One-cycle strobe marking a new word |

## Verification
The bench builds the block with CLK_DIV=4, WIN=5 and STAGES=5. With these values a full window fills in a few dozen bits, so full-scale runs of zeros and ones fit in a short test. The final width is 17 bits, so the one-LSB drop of R8 is exercised, and the non-power-of-two window tests the width growth of R5. Seeded random streams of differing ones-density, an alternating pattern and a reset asserted while the accumulators are busy are compared word by word against a behavioural model of the window sums.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

    // bit offset of slice g in the packed stage bus; slice g is 2+g*l bits wide
    function automatic int slice_off(input int g, input int l);
        return 2 * g + (l * g * (g - 1)) / 2;
    endfunction

    function automatic longint ipow(input longint b, input int e);
        longint r;
        r = 1;
        for (int i = 0; i < e; i++) r = r * b;
        return r;
    endfunction

endpackage

// File: rtl/pdm_clkgen.sv
module pdm_clkgen #(
    parameter int CLK_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pdm_data,
    output logic mic_clk,
    output logic bit_valid,
    output logic bit_value
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
    localparam logic [CW-1:0] HALF_C = CW'(HALF);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mclk;
        logic          din;
        logic          bitv;
        logic          bvld;
    } cg_t;

    cg_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.din  = pdm_data;
        st_d.bvld = (st_q.cnt == LAST);
        if (st_q.cnt == LAST) begin
            st_d.cnt  = '0;
            st_d.bitv = st_q.din;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.mclk = (st_d.cnt < HALF_C);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mic_clk   = st_q.mclk;
    assign bit_valid = st_q.bvld;
    assign bit_value = st_q.bitv;

    // capture instant lies in the low phase of the microphone clock
    assert_capture_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == LAST) |-> !st_q.mclk);
    // a new clock period starts right after the capture instant
    assert_rise_after_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == LAST) |=> st_q.mclk);
endmodule

// File: rtl/pdm_boxcar_stage.sv
module pdm_boxcar_stage #(
    parameter int     IN_W   = 2,
    parameter int     WIN    = 42,
    parameter int     OUT_W  = IN_W + $clog2(WIN),
    parameter longint IN_MAX = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);
    localparam longint OUT_MAX = IN_MAX * WIN;

    typedef struct packed {
        logic [WIN-1:0][IN_W-1:0] dly;
        logic signed [OUT_W-1:0]  sum;
        logic                     vld;
    } bx_t;

    bx_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.sum = st_q.sum + OUT_W'(in_data)
                     - OUT_W'($signed(st_q.dly[WIN-1]));
            st_d.dly = {st_q.dly[WIN-2:0], in_data};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.sum;

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'(st_q.sum) <= OUT_MAX) && (longint'(st_q.sum) >= -OUT_MAX));
    assert_hold_without_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q.sum));
endmodule

// File: rtl/pdm_decim_out.sv
module pdm_decim_out #(
    parameter int IN_W  = 38,
    parameter int WIN   = 42,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic        [OUT_W-1:0] out_data
);
    localparam int DW = (WIN > 2) ? $clog2(WIN) : 1;
    localparam logic [DW-1:0] LAST = DW'(WIN - 1);

    logic [OUT_W-1:0] scaled;

    generate
        if (IN_W >= OUT_W) begin : g_drop
            assign scaled = OUT_W'(in_data >>> (IN_W - OUT_W));
        end else begin : g_widen
            assign scaled = OUT_W'(in_data) << (OUT_W - IN_W);
        end
    endgenerate

    typedef struct packed {
        logic [DW-1:0]    cnt;
        logic [OUT_W-1:0] pcm;
        logic             vld;
    } dc_t;

    dc_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (in_valid) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                st_d.pcm = scaled;
                st_d.vld = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.pcm;

    assert_single_cycle_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    assert_word_follows_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid));
endmodule

// File: rtl/pdm_mic_decimator.sv
module pdm_mic_decimator #(
    parameter int CLK_DIV = 50,
    parameter int WIN     = 42,
    parameter int STAGES  = 6,
    parameter int PCM_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pdm_data,
    output logic             mic_clk,
    output logic [PCM_W-1:0] pcm_data,
    output logic             pcm_valid
);
    import pdm_pkg::*;

    localparam int LW  = $clog2(WIN);
    localparam int FW  = 2 + STAGES * LW;
    localparam int TOT = slice_off(STAGES + 1, LW);

    logic           bit_valid;
    logic           bit_value;
    logic [TOT-1:0] sbus;
    logic [STAGES:0] vbus;

    pdm_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .pdm_data  (pdm_data),
        .mic_clk   (mic_clk),
        .bit_valid (bit_valid),
        .bit_value (bit_value)
    );

    // bit 1 -> -1 (2'b11), bit 0 -> +1 (2'b01)
    assign sbus[1:0] = bit_value ? 2'b11 : 2'b01;
    assign vbus[0]   = bit_valid;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            localparam int IW = 2 + g * LW;
            localparam int OW = IW + LW;
            localparam int IO = slice_off(g, LW);
            localparam int OO = slice_off(g + 1, LW);
            logic signed [OW-1:0] so;

            pdm_boxcar_stage #(
                .IN_W   (IW),
                .WIN    (WIN),
                .OUT_W  (OW),
                .IN_MAX (ipow(WIN, g))
            ) u_stage (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (vbus[g]),
                .in_data   ($signed(sbus[IO +: IW])),
                .out_valid (vbus[g+1]),
                .out_data  (so)
            );
            assign sbus[OO +: OW] = so;
        end
    endgenerate

    pdm_decim_out #(
        .IN_W  (FW),
        .WIN   (WIN),
        .OUT_W (PCM_W)
    ) u_decim (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (vbus[STAGES]),
        .in_data   ($signed(sbus[slice_off(STAGES, LW) +: FW])),
        .out_valid (pcm_valid),
        .out_data  (pcm_data)
    );
endmodule

// File: tb/pdm_mic_decimator_tb.sv
module pdm_mic_decimator_tb_top;
    localparam int DIV = 4;
    localparam int N   = 5;
    localparam int S   = 5;
    localparam int PW  = 16;
    localparam int FW  = 2 + S * $clog2(N);
    localparam int NB  = 1000;
    localparam int NS  = NB / N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pdm_data = 1'b0;
    logic          mic_clk;
    logic [PW-1:0] pcm_data;
    logic          pcm_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int bits [NB];
    int y    [S+1][NB];
    int expv [NS];
    int got  [NS+8];
    int ngot;
    bit prev_v;

    always #10 clk = ~clk;

    pdm_mic_decimator #(.CLK_DIV(DIV), .WIN(N), .STAGES(S), .PCM_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pdm_data(pdm_data),
        .mic_clk(mic_clk), .pcm_data(pcm_data), .pcm_valid(pcm_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int scale(input int v);
        if (FW >= PW) return v >>> (FW - PW);
        else          return v <<< (PW - FW);
    endfunction

    // R3/R4/R5/R6/R8 behavioural model
    task automatic build_model();
        for (int k = 0; k < NB; k++) y[0][k] = bits[k] ? -1 : 1;
        for (int s = 1; s <= S; s++)
            for (int k = 0; k < NB; k++) begin
                int acc = 0;
                for (int j = 0; j < N; j++) if (k - j >= 0) acc += y[s-1][k-j];
                y[s][k] = acc;
            end
        for (int m = 0; m < NS; m++) expv[m] = scale(y[S][(m+1)*N - 1]);
    endtask

    task automatic gen_bits(input int variant);
        for (int k = 0; k < NB; k++) begin
            int seg = k / 100;
            int b;
            if (variant == 1) seg = (seg + 1) % 10;
            case (seg)
                0: b = 0;
                1: b = 1;
                2: b = k % 2;
                3, 4: b = (($urandom % 100) < 50) ? 1 : 0;
                5, 6: b = (($urandom % 100) < 80) ? 1 : 0;
                7: b = (($urandom % 100) < 15) ? 1 : 0;
                default: b = (($urandom % 100) < 35 + (k % 30)) ? 1 : 0;
            endcase
            bits[k] = b;
        end
    endtask

    task automatic drive_bits(input int count);
        bit prev = 0;
        int k = 0;
        while (k < count) begin
            @(negedge clk);
            if (mic_clk && !prev) begin
                pdm_data = bits[k][0];
                k++;
            end
            prev = mic_clk;
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            ngot   <= 0;
            prev_v <= 1'b0;
        end else begin
            if (pcm_valid && prev_v) chk(1'b0, "R7 strobe longer than one cycle", 1, 0);
            if (pcm_valid && ngot < NS + 8) got[ngot] <= $signed(pcm_data);
            if (pcm_valid) ngot <= ngot + 1;
            prev_v <= pcm_valid;
        end
    end

    task automatic check_phase(input string tag);
        chk(ngot == NS, {"R6 word count ", tag}, ngot, NS);
        for (int m = 0; m < NS && m < ngot; m++)
            chk(got[m] == expv[m], {"R4/R8 word value ", tag}, got[m], expv[m]);
    endtask

    initial begin
        int hi, per;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk(mic_clk == 1'b0, "R9 mic_clk in reset", mic_clk, 0);
        chk(pcm_valid == 1'b0, "R9 pcm_valid in reset", pcm_valid, 0);
        chk(pcm_data == '0, "R9 pcm_data in reset", int'(pcm_data), 0);
        rst_n = 1'b1;

        // R1: measure high time and period on a steady-state cycle
        while (!mic_clk) @(negedge clk);
        while (mic_clk)  @(negedge clk);
        while (!mic_clk) @(negedge clk);
        hi = 0; per = 0;
        while (mic_clk)  begin hi++;  per++; @(negedge clk); end
        while (!mic_clk) begin per++; @(negedge clk); end
        chk(hi == DIV / 2, "R1 mic_clk high cycles", hi, DIV / 2);
        chk(per == DIV, "R1 mic_clk period", per, DIV);

        // Phase A: restart cleanly and run from zero state
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        gen_bits(0);
        build_model();
        rst_n = 1'b1;
        drive_bits(NB);
        repeat (12) @(negedge clk);
        check_phase("phase A");
        chk(got[19] == scale(N**S), "R3/R5 positive full scale", got[19], scale(N**S));
        chk(got[39] == scale(-(N**S)), "R3/R5 negative full scale", got[39], scale(-(N**S)));

        // R9: reset while accumulators hold random history
        drive_bits(7);
        rst_n = 1'b0;
        @(negedge clk);
        chk(pcm_valid == 1'b0 && pcm_data == '0, "R9 outputs cleared", int'(pcm_data), 0);
        chk(mic_clk == 1'b0, "R9 mic_clk cleared", mic_clk, 0);
        @(negedge clk);

        // Phase B: different ordering, starts with all ones
        gen_bits(1);
        build_model();
        rst_n = 1'b1;
        drive_bits(NB);
        repeat (12) @(negedge clk);
        check_phase("phase B");
        chk(got[19] == scale(-(N**S)), "R3/R9 first full scale after reset", got[19], scale(-(N**S)));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule